// File: doc/BRIEF.md
# Extended-Register Add/Subtract Execute Unit

This block decodes and executes one class of 32-bit instruction for a 64-bit RISC core: integer addition or subtraction in which the second operand is a register value that is first zero- or sign-extended from a byte, halfword, word or doubleword, and then shifted left by 0 to 4 places. The caller supplies the instruction word, the values read for the two source register indices, and the current stack pointer. The unit returns the destination index, a destination write enable, a marker that the destination is the stack pointer rather than a general register, the 64-bit result, the four condition flags with their own write enable, and an illegal-encoding marker.

Instructions enter on a valid/ready handshake and results leave on a second one. With `REG_OUT=1` (default) a single output register sits between them. An instruction is accepted on a clock edge where `in_valid` and `in_ready` are both high. A result is consumed on an edge where `out_valid` and `out_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, every output holds its value. With `REG_OUT=0` the path is purely combinational: `out_valid` follows `in_valid` and `in_ready` follows `out_ready`.

Top module: `addsub_ext_unit`

## Requirements
- R1: Fields are: bit 31 width select, bit 30 subtract, bit 29 set-flags, bits 28:24 must be 01011, bits 23:22 a reserved pair that must be 00, bit 21 must be 1, bits 20:16 second-operand index, bits 15:13 extension kind, bits 12:10 shift amount, bits 9:5 first-operand index, bits 4:0 destination index. The illegal marker is 1 when the shift exceeds 4, when the reserved pair is nonzero, or when a fixed bit differs. When it is 1, both `out_rd_we` and `out_flags_we` are 0.
- R2: The result is the first operand plus the shifted, extended second operand when bit 30 is 0, and the first operand minus it when bit 30 is 1.
- R3: Extension kind bits [1:0] select the source size: 0 byte, 1 halfword, 2 word, 3 doubleword. Kind bit 2 selects sign extension; when it is 0 the value is zero-extended. The extended value is shifted left by the shift amount.
- R4: When bit 31 is 0 the operation is 32 bits wide, and the low 32 bits of the result are zero-extended to 64.
- R5: First-operand index 31 reads `in_sp_val` instead of `in_rn_val`. Second-operand index 31 reads as zero, and `in_rm_val` is then ignored.
- R6: With set-flags 0 and destination index 31, `out_rd_is_sp` is 1 and `out_rd_we` is 1. With set-flags 1 and destination index 31, `out_rd_we` is 0. For any other index, `out_rd_we` is 1 and `out_rd_is_sp` is 0.
- R7: `out_flags` is {N,Z,C,V}, with N at bit 3. The flags are taken at the operation width. C is the carry out of that width, which for subtraction means no borrow. V is signed overflow at that width. `out_flags_we` equals set-flags for a legal encoding.
- R8: Back-pressure behaves as described above: `in_ready` = !`out_valid` || `out_ready`, and the outputs hold while stalled.
- R9: After reset `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction and operands present |
| in_ready | output | 1 | Unit can accept an instruction |
| in_insn | input | 32 | Instruction word |
| in_rn_val | input | 64 | Value read for the first-operand index |
| in_rm_val | input | 64 | Value read for the second-operand index |
| in_sp_val | input | 64 | Current stack pointer |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_rd_idx | output | 5 | Destination index |
| out_rd_we | output | 1 | Destination write enable |
| out_rd_is_sp | output | 1 | Destination is the stack pointer |
| out_result | output | 64 | Result value |
| out_flags | output | 4 | N, Z, C, V |
| out_flags_we | output | 1 | Flag write enable |
| out_illegal | output | 1 | Illegal encoding |

## Verification
The bench sweeps every extension kind against shifts 0 to 4 for all four operation variants. A swapped sign/zero choice or a wrong size mux would corrupt the upper result bits. Index 31 is aimed at each operand and at the destination with and without set-flags; a unit that mixes up the stack pointer and zero register would read stale operand values or write a discarded result. Subtraction by zero and equal operands probe the no-borrow carry sense. The signed edge values probe V at both widths, where taking flags from the wrong width gives a false or missing overflow. Shifts 5 to 7, nonzero reserved bits and a cleared fixed bit must raise the illegal marker with no write, and a stalled output must not change.

// File: rtl/addsub_ext_pkg.sv
package addsub_ext_pkg;
  localparam int XLEN_P  = 64;
  localparam int IDX_W   = 5;
  localparam int FLAG_W  = 4;

  typedef struct packed {
    logic [IDX_W-1:0]  rd_idx;
    logic              rd_we;
    logic              rd_is_sp;
    logic [XLEN_P-1:0] result;
    logic [FLAG_W-1:0] flags;
    logic              flags_we;
    logic              illegal;
  } ext_res_t;
endpackage

// File: rtl/addsub_ext_opnd.sv
module addsub_ext_opnd #(
  parameter int W   = 64,
  parameter int SHW = 3
) (
  input  logic [W-1:0]   rm_val,
  input  logic [2:0]     kind,
  input  logic [SHW-1:0] amt,
  output logic [W-1:0]   opnd
);
  localparam int NSZ = 4;
  logic [W-1:0] cand [NSZ];

  generate
    for (genvar g = 0; g < NSZ; g++) begin : g_size
      localparam int BITS = 8 << g;
      if (BITS >= W) begin : g_full
        assign cand[g] = rm_val;
      end else begin : g_part
        assign cand[g] = {{(W-BITS){kind[2] & rm_val[BITS-1]}}, rm_val[BITS-1:0]};
      end
    end
  endgenerate

  assign opnd = cand[kind[1:0]] << amt;
endmodule

// File: rtl/addsub_ext_alu.sv
module addsub_ext_alu #(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         wide,
  output logic [W-1:0] res,
  output logic [3:0]   nzcv
);
  localparam int H = W / 2;

  logic [W-1:0] bx;
  logic [W:0]   s_full;
  logic [H:0]   s_half;
  logic         n_f, z_f, c_f, v_f;

  assign bx     = sub ? ~b : b;
  assign s_full = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, sub};
  assign s_half = {1'b0, a[H-1:0]} + {1'b0, bx[H-1:0]} + {{H{1'b0}}, sub};

  always_comb begin
    if (wide) begin
      res = s_full[W-1:0];
      n_f = s_full[W-1];
      z_f = (s_full[W-1:0] == '0);
      c_f = s_full[W];
      v_f = (a[W-1] == bx[W-1]) && (s_full[W-1] != a[W-1]);
    end else begin
      res = {{(W-H){1'b0}}, s_half[H-1:0]};
      n_f = s_half[H-1];
      z_f = (s_half[H-1:0] == '0);
      c_f = s_half[H];
      v_f = (a[H-1] == bx[H-1]) && (s_half[H-1] != a[H-1]);
    end
  end

  assign nzcv = {n_f, z_f, c_f, v_f};
endmodule

// File: rtl/addsub_ext_unit.sv
module addsub_ext_unit
  import addsub_ext_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int SH_MAX  = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_insn,
  input  logic [XLEN-1:0]  in_rn_val,
  input  logic [XLEN-1:0]  in_rm_val,
  input  logic [XLEN-1:0]  in_sp_val,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [4:0]       out_rd_idx,
  output logic             out_rd_we,
  output logic             out_rd_is_sp,
  output logic [XLEN-1:0]  out_result,
  output logic [3:0]       out_flags,
  output logic             out_flags_we,
  output logic             out_illegal
);
  localparam int               SHW      = 3;
  localparam logic [IDX_W-1:0] IDX_TOP  = '1;
  localparam logic [4:0]       CLASS_HI = 5'b01011;

  // field decode
  logic             f_wide, f_sub, f_setf, f_fix21;
  logic [4:0]       f_class;
  logic [1:0]       f_resv;
  logic [IDX_W-1:0] f_rm, f_rn, f_rd;
  logic [2:0]       f_kind;
  logic [SHW-1:0]   f_amt;

  assign f_wide  = in_insn[31];
  assign f_sub   = in_insn[30];
  assign f_setf  = in_insn[29];
  assign f_class = in_insn[28:24];
  assign f_resv  = in_insn[23:22];
  assign f_fix21 = in_insn[21];
  assign f_rm    = in_insn[20:16];
  assign f_kind  = in_insn[15:13];
  assign f_amt   = in_insn[12:10];
  assign f_rn    = in_insn[9:5];
  assign f_rd    = in_insn[4:0];

  logic bad_enc;
  assign bad_enc = (f_class != CLASS_HI) || !f_fix21 || (f_resv != 2'b00) ||
                   (int'(f_amt) > SH_MAX);

  // operand selection
  logic [XLEN-1:0] op_a, rm_sel, op_b, alu_res;
  logic [3:0]      alu_nzcv;

  assign op_a   = (f_rn == IDX_TOP) ? in_sp_val : in_rn_val;
  assign rm_sel = (f_rm == IDX_TOP) ? '0 : in_rm_val;

  addsub_ext_opnd #(.W(XLEN), .SHW(SHW)) opnd_i (
    .rm_val (rm_sel),
    .kind   (f_kind),
    .amt    (f_amt),
    .opnd   (op_b)
  );

  addsub_ext_alu #(.W(XLEN)) alu_i (
    .a    (op_a),
    .b    (op_b),
    .sub  (f_sub),
    .wide (f_wide),
    .res  (alu_res),
    .nzcv (alu_nzcv)
  );

  ext_res_t nxt, cur;
  always_comb begin
    nxt.rd_idx   = f_rd;
    nxt.illegal  = bad_enc;
    nxt.rd_we    = !bad_enc && !(f_setf && f_rd == IDX_TOP);
    nxt.rd_is_sp = !f_setf && (f_rd == IDX_TOP);
    nxt.result   = alu_res;
    nxt.flags    = alu_nzcv;
    nxt.flags_we = !bad_enc && f_setf;
  end

  generate
    if (REG_OUT) begin : g_reg
      logic     vld_q;
      ext_res_t pay_q;
      assign in_ready  = !vld_q || out_ready;
      assign out_valid = vld_q;
      assign cur       = pay_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          pay_q <= '0;
        end else if (in_ready) begin
          vld_q <= in_valid;
          if (in_valid) pay_q <= nxt;
        end
      end

      // R8: stalled output holds
      p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_result) &&
        $stable(out_rd_idx) && $stable(out_flags) && $stable(out_rd_we));
      p_ready_rule_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);
    end else begin : g_comb
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign cur       = nxt;
    end
  endgenerate

  assign out_rd_idx   = cur.rd_idx;
  assign out_rd_we    = cur.rd_we;
  assign out_rd_is_sp = cur.rd_is_sp;
  assign out_result   = cur.result;
  assign out_flags    = cur.flags;
  assign out_flags_we = cur.flags_we;
  assign out_illegal  = cur.illegal;

  p_illegal_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> !out_rd_we && !out_flags_we);
  p_zero_reg_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flags_we && out_rd_idx == IDX_TOP |-> !out_rd_we);
  p_sp_dest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_rd_is_sp |-> !out_flags_we && out_rd_idx == IDX_TOP);
endmodule

// File: tb/addsub_ext_unit_tb_top.sv
`timescale 1ns/1ps
module addsub_ext_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, out_ready = 1'b1;
  logic        in_ready, out_valid;
  logic [31:0] in_insn = '0;
  logic [63:0] in_rn_val = '0, in_rm_val = '0, in_sp_val = '0;
  logic [4:0]  out_rd_idx;
  logic        out_rd_we, out_rd_is_sp, out_flags_we, out_illegal;
  logic [63:0] out_result;
  logic [3:0]  out_flags;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  addsub_ext_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_insn(in_insn), .in_rn_val(in_rn_val), .in_rm_val(in_rm_val),
    .in_sp_val(in_sp_val), .out_valid(out_valid), .out_ready(out_ready),
    .out_rd_idx(out_rd_idx), .out_rd_we(out_rd_we), .out_rd_is_sp(out_rd_is_sp),
    .out_result(out_result), .out_flags(out_flags), .out_flags_we(out_flags_we),
    .out_illegal(out_illegal)
  );

  // expected values
  logic [63:0] e_res;
  logic [3:0]  e_flags;
  logic        e_we, e_sp, e_fwe, e_ill;
  logic [4:0]  e_rd;

  function automatic logic [31:0] mk(bit sf, bit op, bit s, logic [1:0] opt,
      logic [2:0] ext, logic [2:0] sh, logic [4:0] rm, logic [4:0] rn, logic [4:0] rd);
    return {sf, op, s, 5'b01011, opt, 1'b1, rm, ext, sh, rn, rd};
  endfunction

  function automatic logic [63:0] extend(logic [63:0] v, logic [2:0] k);
    case (k)
      3'd0: return {56'd0, v[7:0]};
      3'd1: return {48'd0, v[15:0]};
      3'd2: return {32'd0, v[31:0]};
      3'd4: return 64'($signed(v[7:0]));
      3'd5: return 64'($signed(v[15:0]));
      3'd6: return 64'($signed(v[31:0]));
      default: return v;
    endcase
  endfunction

  task automatic calc(logic [31:0] w, logic [63:0] rnv, logic [63:0] rmv, logic [63:0] spv);
    logic [63:0] a, b, r;
    logic [64:0] f65;
    logic [32:0] f33;
    logic signed [65:0] ws;
    logic signed [33:0] hs;
    logic c, v;
    a = (w[9:5] == 5'd31) ? spv : rnv;
    b = extend((w[20:16] == 5'd31) ? 64'd0 : rmv, w[15:13]) << w[12:10];
    if (w[31]) begin
      f65 = w[30] ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
      r = f65[63:0];
      c = w[30] ? !f65[64] : f65[64];
      ws = w[30] ? ($signed({{2{a[63]}}, a}) - $signed({{2{b[63]}}, b}))
                 : ($signed({{2{a[63]}}, a}) + $signed({{2{b[63]}}, b}));
      v = (ws != $signed({{2{r[63]}}, r}));
      e_flags = {r[63], r == 64'd0, c, v};
    end else begin
      f33 = w[30] ? ({1'b0, a[31:0]} - {1'b0, b[31:0]}) : ({1'b0, a[31:0]} + {1'b0, b[31:0]});
      r = {32'd0, f33[31:0]};
      c = w[30] ? !f33[32] : f33[32];
      hs = w[30] ? ($signed({{2{a[31]}}, a[31:0]}) - $signed({{2{b[31]}}, b[31:0]}))
                 : ($signed({{2{a[31]}}, a[31:0]}) + $signed({{2{b[31]}}, b[31:0]}));
      v = (hs != $signed({{2{r[31]}}, r[31:0]}));
      e_flags = {r[31], r[31:0] == 32'd0, c, v};
    end
    e_res = r;
    e_rd  = w[4:0];
    e_ill = (w[28:24] != 5'b01011) || !w[21] || (w[23:22] != 2'b00) || (w[12:10] > 3'd4);
    e_we  = !e_ill && !(w[29] && w[4:0] == 5'd31);
    e_sp  = !w[29] && w[4:0] == 5'd31;
    e_fwe = !e_ill && w[29];
  endtask

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(out_valid == 1'b1, "R8", "out_valid", 64'(out_valid), 64'd1);
    chk(out_illegal == e_ill, "R1", "illegal", 64'(out_illegal), 64'(e_ill));
    chk(out_rd_we == e_we, tag, "rd_we", 64'(out_rd_we), 64'(e_we));
    chk(out_rd_is_sp == e_sp, "R6", "rd_is_sp", 64'(out_rd_is_sp), 64'(e_sp));
    chk(out_rd_idx == e_rd, "R1", "rd_idx", 64'(out_rd_idx), 64'(e_rd));
    chk(out_flags_we == e_fwe, "R7", "flags_we", 64'(out_flags_we), 64'(e_fwe));
    if (!e_ill) begin
      chk(out_result == e_res, tag, "result", out_result, e_res);
      if (e_fwe) chk(out_flags == e_flags, "R7", "flags", 64'(out_flags), 64'(e_flags));
    end
  endtask

  task automatic run_one(logic [31:0] w, logic [63:0] rnv, logic [63:0] rmv,
                         logic [63:0] spv, string tag);
    @(negedge clk);
    in_insn = w; in_rn_val = rnv; in_rm_val = rmv; in_sp_val = spv;
    in_valid = 1'b1; out_ready = 1'b1;
    calc(w, rnv, rmv, spv);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    compare(tag);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R9", "out_valid in reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9", "out_valid after reset", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R8", "in_ready idle", 64'(in_ready), 64'd1);

    // R3 sweep: every op variant, every extension kind, shift 0..4
    for (int op = 0; op < 4; op++)
      for (int k = 0; k < 8; k++)
        for (int sh = 0; sh < 5; sh++)
          run_one(mk(1'b1, op[1], op[0], 2'b00, 3'(k), 3'(sh), 5'd3, 5'd4, 5'd5),
                  rnd64(), rnd64(), rnd64(), "R3");

    // R2 constrained random
    for (int i = 0; i < 400; i++)
      run_one(mk(1'($urandom), 1'($urandom), 1'($urandom), 2'b00, 3'($urandom),
                 3'($urandom % 5), 5'($urandom), 5'($urandom), 5'($urandom)),
              rnd64(), rnd64(), rnd64(), "R2");

    // R4 32-bit mode with large upper bits
    run_one(mk(1'b0, 1'b0, 1'b1, 2'b00, 3'd3, 3'd0, 5'd1, 5'd2, 5'd3),
            64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h0, "R4");
    run_one(mk(1'b0, 1'b1, 1'b1, 2'b00, 3'd2, 3'd2, 5'd1, 5'd2, 5'd3),
            64'hABCD_0000_0000_0001, 64'h1234_0000_0000_0001, 64'h0, "R4");

    // R5 index 31 on operands
    run_one(mk(1'b1, 1'b0, 1'b0, 2'b00, 3'd3, 3'd0, 5'd1, 5'd31, 5'd3),
            64'h1111, 64'h2, 64'h8000, "R5");
    run_one(mk(1'b1, 1'b0, 1'b0, 2'b00, 3'd3, 3'd0, 5'd31, 5'd2, 5'd3),
            64'h1111, 64'hDEAD_BEEF, 64'h8000, "R5");

    // R6 destination 31
    run_one(mk(1'b1, 1'b0, 1'b0, 2'b00, 3'd3, 3'd1, 5'd1, 5'd2, 5'd31),
            64'h10, 64'h4, 64'h0, "R6");
    run_one(mk(1'b1, 1'b1, 1'b1, 2'b00, 3'd3, 3'd1, 5'd1, 5'd2, 5'd31),
            64'h10, 64'h4, 64'h0, "R6");

    // R7 carry/overflow corners
    run_one(mk(1'b1, 1'b1, 1'b1, 2'b00, 3'd3, 3'd0, 5'd1, 5'd2, 5'd3), 64'd0, 64'd1, 0, "R7");
    run_one(mk(1'b1, 1'b1, 1'b1, 2'b00, 3'd3, 3'd0, 5'd1, 5'd2, 5'd3), 64'd5, 64'd5, 0, "R7");
    run_one(mk(1'b1, 1'b1, 1'b1, 2'b00, 3'd3, 3'd0, 5'd31, 5'd2, 5'd3), 64'd5, 64'd9, 0, "R7");
    run_one(mk(1'b1, 1'b0, 1'b1, 2'b00, 3'd3, 3'd0, 5'd1, 5'd2, 5'd3),
            64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 0, "R7");
    run_one(mk(1'b0, 1'b0, 1'b1, 2'b00, 3'd2, 3'd0, 5'd1, 5'd2, 5'd3),
            64'h7FFF_FFFF, 64'd1, 0, "R7");
    run_one(mk(1'b0, 1'b1, 1'b1, 2'b00, 3'd6, 3'd0, 5'd1, 5'd2, 5'd3),
            64'h8000_0000, 64'd1, 0, "R7");

    // R1 illegal encodings
    for (int sh = 5; sh < 8; sh++)
      run_one(mk(1'b1, 1'b0, 1'b1, 2'b00, 3'd0, 3'(sh), 5'd1, 5'd2, 5'd3),
              rnd64(), rnd64(), 0, "R1");
    for (int o = 1; o < 4; o++)
      run_one(mk(1'b1, 1'b1, 1'b0, 2'(o), 3'd1, 3'd0, 5'd1, 5'd2, 5'd3),
              rnd64(), rnd64(), 0, "R1");
    run_one(mk(1'b1, 1'b0, 1'b1, 2'b00, 3'd0, 3'd0, 5'd1, 5'd2, 5'd3) & ~32'h0020_0000,
            rnd64(), rnd64(), 0, "R1");

    // R8 back-pressure
    begin
      logic [31:0] wa, wb;
      logic [63:0] ra;
      wa = mk(1'b1, 1'b0, 1'b1, 2'b00, 3'd1, 3'd2, 5'd1, 5'd2, 5'd3);
      wb = mk(1'b1, 1'b1, 1'b0, 2'b00, 3'd0, 3'd1, 5'd4, 5'd5, 5'd6);
      @(negedge clk); in_valid = 1'b0; out_ready = 1'b1;
      @(negedge clk);
      in_insn = wa; in_rn_val = 64'h100; in_rm_val = 64'h7; in_sp_val = 0;
      in_valid = 1'b1; out_ready = 1'b0;
      calc(wa, 64'h100, 64'h7, 0);
      ra = e_res;
      @(posedge clk);
      @(negedge clk);
      in_insn = wb; in_rn_val = 64'h900; in_rm_val = 64'h3;
      for (int i = 0; i < 3; i++) begin
        chk(in_ready == 1'b0, "R8", "in_ready stalled", 64'(in_ready), 64'd0);
        chk(out_result == ra, "R8", "held result", out_result, ra);
        chk(out_rd_idx == 5'd3, "R8", "held rd", 64'(out_rd_idx), 64'd3);
        @(negedge clk);
      end
      out_ready = 1'b1;
      #0.5;
      chk(in_ready == 1'b1, "R8", "in_ready drain", 64'(in_ready), 64'd1);
      calc(wb, 64'h900, 64'h3, 0);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      compare("R8");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule